// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects completion and other event pulses from a bank of up to sixteen DMA channels and turns them into one interrupt line. Each channel has four event lanes. Each lane has a pending flag and an enable flag. The flags are packed four bits per channel into 32-bit words, so one word covers eight channels. Software reads and writes them through a small register port.

A pulse on any event lane latches the matching pending flag, whatever the enable flag holds. The interrupt line rises when any latched flag also has its enable set. Software clears pending flags by writing ones to them.

Lane 1 of every channel is the transfer-complete event. A read-only summary word gathers that lane from every channel into one bit per channel, so a handler can find the finished channels with a single read.

Top module: `dma_irq_stat`

## Requirements
- R1: After reset, every enable flag, every pending flag, `irq` and `reg_rdata` are zero.
- R2: Channel n owns bits (n mod 8)*4 to (n mod 8)*4+3 of the enable word at offset 0x00 (channels 0-7) or offset 0x04 (channels 8-15). A write to either offset replaces those bits, and the enable flags change only on such a write.
- R3: The pending words at offsets 0x10 and 0x14 use the same channel-to-bit mapping. A pulse on `evt[n*4+k]` sets pending bit k of channel n at the clock edge where it is sampled, whether or not the matching enable bit is set.
- R4: Writing a pending word clears exactly the bits written as one. Bits written as zero keep their value.
- R5: If an event pulse and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: `irq` is a register. After each edge it holds the OR, over all implemented bits, of pending AND enable as they stood before that edge.
- R7: The read-only word at offset 0x30 has bit n equal to pending bit 1 of channel n, the transfer-complete lane. Bits 16 and up read zero, and writes to 0x30 have no effect.
- R8: `reg_rdata` is registered. When `reg_rd` is sampled high, it takes the addressed word as it stood before that edge. Unmapped offsets return zero. While `reg_rd` is low, `reg_rdata` holds its value.
- R9: Bits that belong to channels at or above NUM_CH read as zero and ignore writes and events. With eight or fewer channels, offsets 0x04 and 0x14 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt | input | NUM_CH*4 | Event pulses, four lanes per channel |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the next falling edge. Each sample therefore sees the result of exactly one rising edge.

A pending flag is visible in a read one edge after its pulse, through the read register. It reaches `irq` one edge after that, because the interrupt register samples the flags as they stood before its edge. The bench model steps in the same way: for every cycle it first computes the read word and the interrupt from its state before the update, then applies the writes and events.

The same stimulus also drives a second instance with twelve channels. Each output is compared on every cycle, so ordering corner cases are checked at the exact cycle they are due: a read in the same cycle as a write, and a clear in the same cycle as an event.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int MAX_CH      = 16;
    localparam int NIB_W       = 4;
    localparam int CH_PER_WORD = 8;
    localparam int DATA_W      = NIB_W * CH_PER_WORD;
    localparam int FULL_W      = MAX_CH * NIB_W;
    localparam int ADDR_W      = 8;
    localparam int DONE_LANE   = 1;

    localparam logic [ADDR_W-1:0] OFS_EN_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DONE    = 8'h30;

    typedef struct packed {
        logic [NIB_W-1:0] en;
        logic [NIB_W-1:0] pend;
    } chan_st_t;

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [NIB_W-1:0] en_wdata,
    input  logic [NIB_W-1:0] pend_clr,
    input  logic [NIB_W-1:0] evt,
    output logic [NIB_W-1:0] en_o,
    output logic [NIB_W-1:0] pend_o
);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) begin
            st_d.en = en_wdata;
        end
        // set wins over clear
        st_d.pend = (st_q.pend & ~pend_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;

    // R3
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend_o & $past(evt)) == $past(evt)));

    // R4
    clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_clr & ~evt) != '0) |=> ((pend_o & $past(pend_clr & ~evt)) == '0));

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_o));

    // R3
    pend_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((pend_o & ~$past(pend_o)) == '0));

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
    import dma_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [FULL_W-1:0] en_flat,
    input  logic [FULL_W-1:0] pend_flat,
    input  logic [MAX_CH-1:0] done_vec,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        unique case (addr)
            OFS_EN_LO:   word = en_flat[0 +: DATA_W];
            OFS_EN_HI:   word = en_flat[DATA_W +: DATA_W];
            OFS_PEND_LO: word = pend_flat[0 +: DATA_W];
            OFS_PEND_HI: word = pend_flat[DATA_W +: DATA_W];
            OFS_DONE:    word = {{(DATA_W-MAX_CH){1'b0}}, done_vec};
            default:     word = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [7:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_CH*4-1:0]     evt,
    output logic                    irq
);

    localparam int IMPL_W = NUM_CH * NIB_W;

    logic [FULL_W-1:0] en_flat;
    logic [FULL_W-1:0] pend_flat;
    logic [MAX_CH-1:0] done_vec;
    logic [DATA_W-1:0] rd_word;

    top_st_t st_d, st_q;

    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
        localparam int WORD = c / CH_PER_WORD;
        localparam int LANE = c % CH_PER_WORD;
        localparam logic [ADDR_W-1:0] EN_OFS   = (WORD == 0) ? OFS_EN_LO : OFS_EN_HI;
        localparam logic [ADDR_W-1:0] PEND_OFS = (WORD == 0) ? OFS_PEND_LO : OFS_PEND_HI;
        if (c < NUM_CH) begin : g_impl
            logic              en_wr_c;
            logic [NIB_W-1:0]  clr_c;
            assign en_wr_c = reg_wr && (reg_addr == EN_OFS);
            assign clr_c   = (reg_wr && (reg_addr == PEND_OFS)) ?
                             reg_wdata[LANE*NIB_W +: NIB_W] : '0;
            dma_irq_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_wr    (en_wr_c),
                .en_wdata (reg_wdata[LANE*NIB_W +: NIB_W]),
                .pend_clr (clr_c),
                .evt      (evt[c*NIB_W +: NIB_W]),
                .en_o     (en_flat[c*NIB_W +: NIB_W]),
                .pend_o   (pend_flat[c*NIB_W +: NIB_W])
            );
        end else begin : g_absent
            assign en_flat[c*NIB_W +: NIB_W]   = '0;
            assign pend_flat[c*NIB_W +: NIB_W] = '0;
        end
        assign done_vec[c] = pend_flat[c*NIB_W + DONE_LANE];
    end

    dma_irq_rdmux u_rdmux (
        .addr      (reg_addr),
        .en_flat   (en_flat),
        .pend_flat (pend_flat),
        .done_vec  (done_vec),
        .word      (rd_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(pend_flat & en_flat);
        if (reg_rd) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.irq;

    // R6
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(pend_flat & en_flat))));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R8
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != OFS_EN_LO && reg_addr != OFS_EN_HI &&
         reg_addr != OFS_PEND_LO && reg_addr != OFS_PEND_HI &&
         reg_addr != OFS_DONE) |=> (reg_rdata == '0));

    // R7
    done_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DONE && evt == '0) |=> $stable(done_vec));

endmodule

// File: tb/sim_dma_irq_stat.sv
module sim_dma_irq_stat;

    localparam int CLK_P = 10;
    localparam int CH1   = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [63:0] evt;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] m_en0, m_pd0, m_en1, m_pd1;
    logic [31:0] m_rd0, m_rd1;
    logic        m_irq0, m_irq1;

    localparam logic [63:0] MASK0 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MASK1 = 64'h0000_FFFF_FFFF_FFFF;

    always #(CLK_P/2) clk = ~clk;

    dma_irq_stat #(.NUM_CH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd0),
        .evt(evt), .irq(irq0));

    dma_irq_stat #(.NUM_CH(CH1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd1),
        .evt(evt[CH1*4-1:0]), .irq(irq1));

    function automatic logic [31:0] read_word(input logic [7:0] a,
                                              input logic [63:0] en,
                                              input logic [63:0] pd);
        logic [31:0] s;
        s = '0;
        for (int c = 0; c < 16; c++) s[c] = pd[c*4+1];
        case (a)
            8'h00:   return en[31:0];
            8'h04:   return en[63:32];
            8'h10:   return pd[31:0];
            8'h14:   return pd[63:32];
            8'h30:   return s;
            default: return '0;
        endcase
    endfunction

    task automatic model_step(inout logic [63:0] en, inout logic [63:0] pd,
                              inout logic [31:0] rd, inout logic irqm,
                              input logic [63:0] mask);
        logic [63:0] clr;
        if (reg_rd) rd = read_word(reg_addr, en, pd);
        irqm = |(en & pd);
        clr  = '0;
        if (reg_wr && reg_addr == 8'h00) en[31:0]  = reg_wdata;
        if (reg_wr && reg_addr == 8'h04) en[63:32] = reg_wdata;
        if (reg_wr && reg_addr == 8'h10) clr[31:0]  = reg_wdata;
        if (reg_wr && reg_addr == 8'h14) clr[63:32] = reg_wdata;
        en = en & mask;
        pd = ((pd & ~clr) | evt) & mask;
    endtask

    task automatic check(input string tg, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tg, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; evt = '0;
    endtask

    // one cycle: inputs already set at a falling edge
    task automatic cyc(input string tg);
        model_step(m_en0, m_pd0, m_rd0, m_irq0, MASK0);
        model_step(m_en1, m_pd1, m_rd1, m_irq1, MASK1);
        @(posedge clk);
        @(negedge clk);
        check(tg, "rdata u0", rd0, m_rd0);
        check(tg, "rdata u1", rd1, m_rd1);
        check("R6", "irq u0", {31'b0, irq0}, {31'b0, m_irq0});
        check("R6", "irq u1", {31'b0, irq1}, {31'b0, m_irq1});
        idle();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tg);
        reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(tg);
    endtask

    task automatic rd(input logic [7:0] a, input string tg);
        reg_rd = 1; reg_addr = a; cyc(tg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [7];
        addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h30, 8'h08, 8'h2C};
        void'($urandom(32'd2024));
        idle();
        rst_n = 0;
        m_en0 = '0; m_pd0 = '0; m_en1 = '0; m_pd1 = '0;
        m_rd0 = '0; m_rd1 = '0; m_irq0 = 0; m_irq1 = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rdata u0 in reset", rd0, 32'h0);
        check("R1", "irq u0 in reset", {31'b0, irq0}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h10, "R1");
        rd(8'h14, "R1"); rd(8'h30, "R1");

        // R2 enable mapping and replace
        wr(8'h00, 32'hA5A5_5A5A, "R2");
        rd(8'h00, "R2");
        wr(8'h04, 32'h0000_0020, "R2");
        rd(8'h04, "R2");
        wr(8'h00, 32'h0000_0000, "R2");
        rd(8'h00, "R2");

        // R3 event on channel 9 lane 1 (bit 37), enabled
        evt[37] = 1'b1; cyc("R3");
        rd(8'h14, "R3");
        check("R3", "pend ch9 lane1", rd0, 32'h0000_0020);
        // R7 done summary
        rd(8'h30, "R7");
        check("R7", "done bit ch9", rd0, 32'h0000_0200);
        check("R6", "irq set by enabled pending", {31'b0, irq0}, 32'h1);
        wr(8'h30, 32'hFFFF_FFFF, "R7");
        rd(8'h30, "R7");
        check("R7", "done after write", rd0, 32'h0000_0200);
        // R3 disabled event still latches
        evt[2] = 1'b1; cyc("R3");
        rd(8'h10, "R3");
        check("R3", "pend without enable", rd0, 32'h0000_0004);

        // R4 write-one-to-clear
        evt = 64'h0000_00F0_0000_0F00; cyc("R4");
        wr(8'h10, 32'h0000_0300, "R4");
        rd(8'h10, "R4");
        check("R4", "partial clear", rd0, 32'h0000_0C04);

        // R5 clear and event same cycle
        reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'hFFFF_FFFF; evt[3] = 1'b1;
        cyc("R5");
        rd(8'h10, "R5");
        check("R5", "set wins", rd0, 32'h0000_0008);
        wr(8'h14, 32'hFFFF_FFFF, "R4");
        rd(8'h14, "R4");
        check("R4", "clear all high", rd0, 32'h0);

        // R9 absent channels on the 12-channel instance
        wr(8'h04, 32'hFFFF_FFFF, "R9");
        rd(8'h04, "R9");
        check("R9", "u1 upper enables", rd1, 32'h0000_FFFF);
        evt = 64'hFFFF_0000_0000_0000; cyc("R9");
        rd(8'h14, "R9");
        check("R9", "u1 upper pending", rd1, 32'h0);

        // R8 unmapped and hold
        rd(8'h08, "R8");
        check("R8", "unmapped", rd0, 32'h0);
        cyc("R8");

        // random mix
        for (int i = 0; i < 600; i++) begin
            reg_wr    = ($urandom % 3) == 0;
            reg_rd    = ($urandom % 2) == 0;
            reg_addr  = addrs[$urandom % 7];
            reg_wdata = $urandom;
            evt       = (($urandom % 3) == 0) ?
                        ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}) : '0;
            cyc("R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule